// File: doc/BRIEF.md
# Four-channel prescaled PWM bank

This block generates four independent pulse-width modulated outputs from one clock. Software programs it over a small register bus that has an address, a write strobe, write data and combinational read data. One shared control word holds each channel's run bit and its two-bit clock-prescale code. Each channel also has a configuration word that gives its period length (timebase) and its high time (duty), both counted in prescaled steps.

A running channel divides the clock by 1, 8, 64 or 512. It then steps a counter from 0 up to timebase minus 1. The output is high while the step count is below the duty count. A new timebase, duty or prescale code written to a running channel is held back until the current period ends, so an update cannot produce a shortened pulse. When a channel is stopped, its output is held low and its counters are cleared. Starting it again begins a fresh period at step 0.

Top module: `pwm_bank`

## Requirements
- R1: The four channels run independently. Each drives its own bit of `pwm_out` from its own settings, and a stopped channel stays low while the others run.
- R2: In the control word at byte address 0x00, bit n (n = 0..3) runs channel n. Bits 4+2n+1 : 4+2n hold that channel's prescale code.
- R3: Prescale code 0 advances the step counter on every clock, code 1 every 8 clocks, code 2 every 64 clocks and code 3 every 512 clocks. A period therefore lasts timebase × divider clocks.
- R4: The configuration word of channel n sits at byte address 0x04 + 4n, with the timebase in bits 15:0 and the duty in bits 31:16. For 0 < duty < timebase the output is high for duty × divider clocks and low for (timebase − duty) × divider clocks in each period.
- R5: A duty of 0 keeps the output low. A duty greater than or equal to the timebase keeps it high.
- R6: A running channel whose timebase is 0 keeps its output low.
- R7: Timebase, duty and prescale values written while a channel runs take effect only at the next period boundary. The period in progress keeps its old high and low lengths.
- R8: A stopped channel drives low from the second clock edge after its run bit is cleared. Setting the run bit starts step 0 at the next clock edge, so an output with non-zero duty and timebase goes high one cycle after the control word shows the bit set.
- R9: Every register reads back the last value written to it. Control bits above bit 11 read as zero. Reads of unmapped addresses return zero, and writes to unmapped addresses change no register.
- R10: After reset all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe; data is taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | One PWM output per channel, bit n for channel n |

## Verification
The readback properties assume that `bus_addr` and `bus_wdata` are stable for the whole cycle in which `bus_wr` is high, and that the bus stays idle while reset is active. The bench drives every bus field at the falling edge and holds it through one rising edge, so this assumption holds. The start-of-period property assumes the configuration word is not rewritten in the same cycle the run bit is first seen. The bench always writes a channel's configuration at least one cycle before it sets that channel's run bit, and it measures pulse widths only on outputs whose settings stay fixed for the whole measured window.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Shared sizing of the PWM bank.
    localparam int NUM_CH    = 4;   // number of channels
    localparam int CNT_W     = 16;  // width of the timebase and duty fields
    localparam int PSC_W     = 2;   // width of one prescale code
    localparam int PSC_STEP  = 3;   // each code step multiplies the divider by 2**PSC_STEP
    localparam int ADDR_W    = 8;   // byte address width
    localparam int DATA_W    = 32;  // bus data width (equals 2*CNT_W)

    // One channel configuration word: duty in the upper half, timebase in the lower.
    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] tb;
    } chan_cfg_t;

endpackage

// File: rtl/pwm_prescaler.sv
// Clock prescaler: emits one tick every 2**(PSC_STEP*code) clocks while run is high.
module pwm_prescaler #(
    parameter int PSC_W    = 2,
    parameter int PSC_STEP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);
    localparam int PRE_W = PSC_STEP * ((1 << PSC_W) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    always_comb begin
        span  = {{PRE_W{1'b0}}, 1'b1} << (PSC_STEP * int'(code));
        limit = span[PRE_W-1:0] - PRE_W'(1);
        tick  = run && (s_q.cnt == limit);
        s_d   = s_q;
        if (!run || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: holds the active settings, steps through a period, and
// takes new settings only when a period ends.
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int CH_CNT_W    = CNT_W,
    parameter int CH_PSC_W    = PSC_W,
    parameter int CH_PSC_STEP = PSC_STEP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [CH_PSC_W-1:0] psc_code,
    input  chan_cfg_t           cfg,
    output logic                pwm
);
    typedef struct packed {
        logic                running;
        logic [CH_CNT_W-1:0] step;
        chan_cfg_t           act;
        logic [CH_PSC_W-1:0] act_psc;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      tick;
    logic      last_step;

    pwm_prescaler #(
        .PSC_W    (CH_PSC_W),
        .PSC_STEP (CH_PSC_STEP)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.running),
        .code  (s_q.act_psc),
        .tick  (tick)
    );

    always_comb begin
        s_d       = s_q;
        last_step = (s_q.act.tb <= CH_CNT_W'(1)) ||
                    (s_q.step >= s_q.act.tb - CH_CNT_W'(1));
        if (!en) begin
            // Stopped: clear the counters and keep tracking the live settings.
            s_d.running = 1'b0;
            s_d.step    = '0;
            s_d.act     = cfg;
            s_d.act_psc = psc_code;
        end else if (!s_q.running) begin
            // First cycle with the run bit set: start a period at step 0.
            s_d.running = 1'b1;
            s_d.step    = '0;
            s_d.act     = cfg;
            s_d.act_psc = psc_code;
        end else if (tick) begin
            if (last_step) begin
                // Period boundary: the only point where new settings are taken.
                s_d.step    = '0;
                s_d.act     = cfg;
                s_d.act_psc = psc_code;
            end else begin
                s_d.step = s_q.step + CH_CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm = s_q.running && (s_q.act.tb != '0) && (s_q.step < s_q.act.duty);

endmodule

// File: rtl/pwm_regfile.sv
// Register file: one control word and one configuration word per channel.
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int RF_NUM_CH = NUM_CH,
    parameter int RF_PSC_W  = PSC_W,
    parameter int RF_ADDR_W = ADDR_W,
    parameter int RF_DATA_W = DATA_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [RF_ADDR_W-1:0]          bus_addr,
    input  logic                          bus_wr,
    input  logic [RF_DATA_W-1:0]          bus_wdata,
    output logic [RF_DATA_W-1:0]          bus_rdata,
    output logic [RF_NUM_CH-1:0]          ch_en,
    output logic [RF_NUM_CH*RF_PSC_W-1:0] ch_psc,
    output chan_cfg_t [RF_NUM_CH-1:0]     ch_cfg
);
    localparam int CTRL_W     = RF_NUM_CH + RF_NUM_CH * RF_PSC_W;
    localparam int CFG_BASE   = 4;
    localparam int CFG_STRIDE = 4;

    typedef struct packed {
        logic [CTRL_W-1:0]            ctrl;
        chan_cfg_t [RF_NUM_CH-1:0]    cfg;
    } rf_state_t;

    rf_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        bus_rdata = '0;
        if (bus_addr == '0) begin
            bus_rdata = RF_DATA_W'(s_q.ctrl);
        end
        for (int n = 0; n < RF_NUM_CH; n++) begin
            if (bus_addr == RF_ADDR_W'(CFG_BASE + CFG_STRIDE * n)) begin
                bus_rdata = s_q.cfg[n];
            end
        end
        if (bus_wr) begin
            if (bus_addr == '0) begin
                s_d.ctrl = bus_wdata[CTRL_W-1:0];
            end
            for (int n = 0; n < RF_NUM_CH; n++) begin
                if (bus_addr == RF_ADDR_W'(CFG_BASE + CFG_STRIDE * n)) begin
                    s_d.cfg[n] = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ch_en  = s_q.ctrl[RF_NUM_CH-1:0];
    assign ch_psc = s_q.ctrl[CTRL_W-1:RF_NUM_CH];
    assign ch_cfg = s_q.cfg;

endmodule

// File: rtl/pwm_bank.sv
// Top level: register file plus one PWM channel per output.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH  = NUM_CH,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0]       ch_en;
    logic [NCH*PSC_W-1:0] ch_psc;
    chan_cfg_t [NCH-1:0]  ch_cfg;

    pwm_regfile #(
        .RF_NUM_CH (NCH),
        .RF_PSC_W  (PSC_W),
        .RF_ADDR_W (AW),
        .RF_DATA_W (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_en     (ch_en),
        .ch_psc    (ch_psc),
        .ch_cfg    (ch_cfg)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm_channel #(
            .CH_CNT_W    (CNT_W),
            .CH_PSC_W    (PSC_W),
            .CH_PSC_STEP (PSC_STEP)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[n]),
            .psc_code (ch_psc[n*PSC_W +: PSC_W]),
            .cfg      (ch_cfg[n]),
            .pwm      (pwm_out[n])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
// Property checker for pwm_bank, attached with bind.
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_wr,
    input logic [DW-1:0]       bus_wdata,
    input logic [DW-1:0]       bus_rdata,
    input logic [NCH-1:0]      pwm_out,
    input logic [NCH-1:0]      ch_en,
    input chan_cfg_t [NCH-1:0] ch_cfg
);
    localparam int          CTRL_W    = NCH + NCH * PSC_W;
    localparam logic [DW-1:0] CTRL_MASK = DW'((64'd1 << CTRL_W) - 64'd1);

    // R10: outputs stay low while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_low_r10: assert (pwm_out == '0)
                else $error("pwm_out not low in reset");
        end
    end

    // R9: a control write is visible on the read port in the next cycle.
    p_ctrl_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0) |=>
            (bus_addr != '0 || bus_rdata == ($past(bus_wdata) & CTRL_MASK)));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R4: a configuration write reads back unchanged.
        p_cfg_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == AW'(4 + 4 * n)) |=>
                (bus_addr != AW'(4 + 4 * n) || bus_rdata == $past(bus_wdata)));

        // R8: one cycle after the run bit is seen low, the output is low.
        p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[n] |=> !pwm_out[n]);

        // R8: starting a channel with non-zero settings drives it high at once.
        p_start_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ch_en[n]) && ch_cfg[n].duty != '0 && ch_cfg[n].tb != '0) |=> pwm_out[n]);
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NCH (NCH),
    .AW  (AW),
    .DW  (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ch_en     (ch_en),
    .ch_cfg    (ch_cfg)
);

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // Vectors: {prescale code, timebase, duty}, with 0 < duty < timebase.
    localparam logic [33:0] VEC [0:5] = '{
        {2'd0, 16'd10,  16'd3},
        {2'd1, 16'd4,   16'd1},
        {2'd2, 16'd3,   16'd2},
        {2'd3, 16'd2,   16'd1},
        {2'd0, 16'd255, 16'd254},
        {2'd1, 16'd16,  16'd8}
    };

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cfgw(input int tb, input int duty);
        return {16'(duty), 16'(tb)};
    endfunction

    // Waits for a low-to-high change, then counts high and low cycles of one period.
    task automatic measure(input int ch, output int hi, output int lo);
        int t = 0;
        hi = -1; lo = -1;
        do begin @(negedge clk); t++; end while (pwm_out[ch] && t < 5000);
        do begin @(negedge clk); t++; end while (!pwm_out[ch] && t < 5000);
        if (t >= 5000) return;
        hi = 0;
        while (pwm_out[ch] && hi < 5000) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm_out[ch] && lo < 5000) begin lo++; @(negedge clk); end
    endtask

    task automatic count_high(input int ch, input int n, output int highs);
        highs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) highs++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi, lo, h1, h2;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10", "pwm_out after reset", pwm_out, 0);
        rd(8'h00, d); chk("R10", "ctrl after reset", d, 0);
        for (int n = 0; n < 4; n++) begin
            rd(8'(4 + 4 * n), d); chk("R10", "cfg after reset", d, 0);
        end

        // R9: readback, control width, unmapped addresses
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h08, 32'h1234_5678);
        wr(8'h00, 32'hFFFF_F000);
        rd(8'h04, d); chk("R9", "cfg0 readback", d, 32'hDEAD_BEEF);
        rd(8'h08, d); chk("R9", "cfg1 readback", d, 32'h1234_5678);
        rd(8'h00, d); chk("R9", "ctrl upper bits read zero", d, 0);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R9", "unmapped read", d, 0);
        rd(8'h04, d); chk("R9", "cfg0 after unmapped write", d, 32'hDEAD_BEEF);
        rd(8'h00, d); chk("R9", "ctrl after unmapped write", d, 0);
        rd(8'h14, d); chk("R9", "address past cfg3 reads zero", d, 0);

        // R2 R3 R4: vector table walked over the channels
        for (int i = 0; i < 6; i++) begin
            int ch   = i % 4;
            int psc  = int'(VEC[i][33:32]);
            int tb   = int'(VEC[i][31:16]);
            int duty = int'(VEC[i][15:0]);
            int dv   = 1 << (3 * psc);
            wr(8'h00, 32'h0);
            repeat (3) @(negedge clk);
            wr(8'(4 + 4 * ch), cfgw(tb, duty));
            wr(8'h00, (32'd1 << ch) | (32'(psc) << (4 + 2 * ch)));
            measure(ch, hi, lo);
            chk("R4", "high cycles", hi, duty * dv);
            chk("R3", "low cycles", lo, (tb - duty) * dv);
        end

        // R1: two channels running at once, the others stay low
        wr(8'h00, 32'h0);
        repeat (3) @(negedge clk);
        wr(8'h08, cfgw(6, 2));
        wr(8'h0C, cfgw(4, 1));
        wr(8'h00, 32'h6 | (32'd1 << 8));
        measure(1, hi, lo);
        chk("R1", "ch1 high", hi, 2); chk("R1", "ch1 low", lo, 4);
        measure(2, hi, lo);
        chk("R1", "ch2 high", hi, 8); chk("R1", "ch2 low", lo, 24);
        count_high(0, 40, h1); chk("R1", "ch0 idle highs", h1, 0);
        count_high(3, 40, h2); chk("R1", "ch3 idle highs", h2, 0);

        // R5: duty limits
        wr(8'h00, 32'h0);
        wr(8'h10, cfgw(10, 0));
        wr(8'h00, 32'h8);
        count_high(3, 100, h1); chk("R5", "duty 0 highs", h1, 0);
        wr(8'h00, 32'h0);
        wr(8'h10, cfgw(10, 20));
        wr(8'h00, 32'h8);
        repeat (2) @(negedge clk);
        count_high(3, 100, h1); chk("R5", "duty above timebase highs", h1, 100);

        // R6: timebase zero
        wr(8'h00, 32'h0);
        wr(8'h10, cfgw(0, 5));
        wr(8'h00, 32'h8);
        count_high(3, 100, h1); chk("R6", "timebase 0 highs", h1, 0);

        // R7: update while running takes effect at the boundary
        wr(8'h00, 32'h0);
        wr(8'h04, cfgw(10, 5));
        wr(8'h00, 32'h1);
        repeat (3) @(negedge clk);
        do @(negedge clk); while (pwm_out[0]);
        do @(negedge clk); while (!pwm_out[0]);
        hi = 1;
        wr(8'h04, cfgw(6, 2));
        hi += 2;
        while (pwm_out[0] && hi < 100) begin @(negedge clk); if (pwm_out[0]) hi++; end
        lo = 0;
        while (!pwm_out[0] && lo < 100) begin lo++; @(negedge clk); end
        chk("R7", "old high kept", hi, 5);
        chk("R7", "old low kept", lo, 5);
        measure(0, hi, lo);
        chk("R7", "new high", hi, 2);
        chk("R7", "new low", lo, 4);

        // R8: stop holds low, start begins a fresh period
        wr(8'h04, cfgw(10, 3));
        wr(8'h00, 32'h0);
        @(negedge clk);
        count_high(0, 50, h1); chk("R8", "stopped highs", h1, 0);
        wr(8'h00, 32'h1);
        chk("R8", "output right after start write", pwm_out[0], 0);
        @(negedge clk);
        chk("R8", "output one cycle later", pwm_out[0], 1);
        hi = 0;
        while (pwm_out[0] && hi < 100) begin hi++; @(negedge clk); end
        chk("R8", "first high from step 0", hi, 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule